// File: doc/BRIEF.md
# Status Register and Write-Permission Guard

This block keeps the protection state of a small serial nonvolatile memory and decides, every cycle, whether a data write or a status-register write may go ahead. It holds a write-enable latch, a protect-enable bit and a two-bit block-protect field. It puts them together with the busy flag of the write engine into one status byte that the command interface shifts out. The command decoder sends one-cycle strobes when a write-enable, write-disable or status-write command has been received. It also supplies the chip-select level, a strobe for every serial bit, the write-protect pin level and the address being targeted.

The block answers with two permits and a status-commit pulse. The array permit combines the latch with a block map that protects nothing, the upper quarter, the upper half or the whole array. The status permit needs the latch, and it is withheld while the protect-enable bit is set and the write-protect pin is low. A status write that has been accepted stays pending until chip select rises. If the write-protect pin goes low while the write is guarded, the pending write is dropped. Once the commit pulse has gone out, the pin has no further effect. The persistent bits are plain registers with reset values set by parameters.

A four-state machine controls the sequence. ST_IDLE waits for commands. A write-enable strobe leads to ST_WREN_ARM. An accepted status-write strobe leads to ST_SR_HOLD. A raised busy flag, from any state, leads to ST_ENGINE. ST_WREN_ARM sets the latch and returns to idle when chip select rises; if another serial bit arrives first it returns to idle without setting the latch. ST_SR_HOLD commits and returns to idle on chip-select rise while the status permit still holds, and returns to idle without committing as soon as the permit is lost. ST_ENGINE ignores every command and, when busy falls, clears the latch and returns to idle.

Top module: `wsp_status_guard`

## Requirements
- R1: status_o is {protect-enable in bit 7, zeros in bits 6..4, block-protect in bits 3..2, write-enable latch in bit 1, busy in bit 0}. After reset, with default parameters and busy low, it reads 8'h00 and both permits are 0.
- R2: status_o bit 0 equals busy_i in the same cycle, with no register in between.
- R3: A write-enable strobe sets the latch only if sel_n_i rises before any further bit_stb_i. If a bit strobe comes first, the latch is left as it was.
- R4: A write-disable strobe clears the latch one clock later.
- R5: array_wr_ok_o is 1 only when the latch is 1 and the address is outside the protected range. Block-protect 2'b00 protects nothing, 2'b01 protects addresses at or above 3/4 of the array (0x600..0x7FF for 11 address bits), 2'b10 protects the upper half (0x400..0x7FF), and 2'b11 protects every address.
- R6: sr_wr_ok_o is 1 exactly when the latch is 1 and protect-enable and a low wp_n_i are not both present.
- R7: A committed status write changes only bits 7, 3 and 2. The change takes effect at the clock edge that sees sel_n_i high in ST_SR_HOLD, and sr_commit_o is high for exactly that one cycle.
- R8: A status-write strobe received while sr_wr_ok_o is 0 produces no commit pulse and changes neither the status bits nor the latch.
- R9: With protect-enable at 1, wp_n_i going low at any point between the accepted status byte and the chip-select rise, including the very cycle of the rise, cancels the write. With protect-enable at 0, wp_n_i has no effect.
- R10: While busy_i is high, write-enable, write-disable and status-write strobes have no effect.
- R11: The latch reads 0 in the cycle after busy_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Chip-select level, low while a command session is open |
| bit_stb_i | input | 1 | One-cycle pulse for each serial bit received after an opcode |
| wren_stb_i | input | 1 | Write-enable opcode received |
| wrdi_stb_i | input | 1 | Write-disable opcode received |
| wrsr_stb_i | input | 1 | Status-write data byte received |
| wrsr_byte_i | input | 8 | Status-write data byte |
| wp_n_i | input | 1 | Write-protect pin level, active low |
| busy_i | input | 1 | Write engine internal cycle in progress |
| wr_addr_i | input | ADDR_W | Target address of the pending data write |
| status_o | output | 8 | Assembled status byte |
| array_wr_ok_o | output | 1 | Data write to wr_addr_i permitted |
| sr_wr_ok_o | output | 1 | Status-register write permitted |
| sr_commit_o | output | 1 | One-cycle pulse: status write committed, engine may start |

## Verification
Two functions can land on the same clock edge: the chip-select rise that commits a pending status write, and the write-protect pin drop that must cancel it. The bench lowers wp_n_i in the same cycle in which it raises sel_n_i while protect-enable is 1. It passes only if no commit pulse appears and the status byte keeps its old value. The same stimulus is then repeated with protect-enable at 0, where the commit must go through. In a second coincidence, write-disable and status-write strobes arrive while busy is high. They must leave the latch set until busy falls, and then it must clear.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WREN_ARM = 2'd1,
        ST_SR_HOLD  = 2'd2,
        ST_ENGINE   = 2'd3
    } wsp_state_e;

    // Bit positions in the status byte (decoded by the command interface).
    localparam int unsigned SR_WPEN_BIT = 7;
    localparam int unsigned SR_BP_HI    = 3;
    localparam int unsigned SR_BP_LO    = 2;
    localparam int unsigned SR_WEL_BIT  = 1;
    localparam int unsigned SR_RDY_BIT  = 0;

    // Bits a status write may change.
    localparam logic [7:0] SR_WR_MASK = 8'h8C;

    // Block-protect encodings.
    localparam logic [1:0] PROT_NONE    = 2'b00;
    localparam logic [1:0] PROT_QUARTER = 2'b01;
    localparam logic [1:0] PROT_HALF    = 2'b10;
    localparam logic [1:0] PROT_ALL     = 2'b11;

    function automatic logic [7:0] pack_status(input logic [7:0] nv,
                                               input logic       wel,
                                               input logic       rdy);
        logic [7:0] s;
        s = nv & SR_WR_MASK;
        s[SR_WEL_BIT] = wel;
        s[SR_RDY_BIT] = rdy;
        return s;
    endfunction

endpackage

// File: rtl/wsp_block_map.sv
module wsp_block_map #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_prot_o
);
    import wsp_pkg::*;

    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);

    always_comb begin
        unique case (bp_i)
            PROT_NONE:    in_prot_o = 1'b0;
            PROT_QUARTER: in_prot_o = (addr_i >= QTR_BASE);
            PROT_HALF:    in_prot_o = (addr_i >= HALF_BASE);
            PROT_ALL:     in_prot_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/wsp_guard.sv
module wsp_guard (
    input  logic wel_i,
    input  logic wpen_i,
    input  logic wp_n_i,
    input  logic in_prot_i,
    output logic array_ok_o,
    output logic sr_ok_o
);
    logic pin_lock;

    always_comb begin
        pin_lock   = wpen_i & ~wp_n_i;
        array_ok_o = wel_i & ~in_prot_i;
        sr_ok_o    = wel_i & ~pin_lock;
    end

endmodule

// File: rtl/wsp_seq.sv
module wsp_seq #(
    parameter logic [7:0] RST_NV = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n_i,
    input  logic       bit_stb_i,
    input  logic       wren_stb_i,
    input  logic       wrdi_stb_i,
    input  logic       wrsr_stb_i,
    input  logic [7:0] wrsr_byte_i,
    input  logic       busy_i,
    input  logic       sr_ok_i,
    output logic       wel_o,
    output logic [7:0] nv_o,
    output logic       commit_o
);
    import wsp_pkg::*;

    wsp_state_e state_q, state_d;
    logic       set_wel, clr_wel, take_byte, do_commit;
    logic [7:0] pend_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control strobes.
    always_comb begin
        state_d   = state_q;
        set_wel   = 1'b0;
        clr_wel   = 1'b0;
        take_byte = 1'b0;
        do_commit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (busy_i) begin
                    state_d = ST_ENGINE;
                end else if (wren_stb_i) begin
                    state_d = ST_WREN_ARM;
                end else if (wrsr_stb_i && sr_ok_i) begin
                    state_d   = ST_SR_HOLD;
                    take_byte = 1'b1;
                end else if (wrdi_stb_i) begin
                    clr_wel = 1'b1;
                end
            end
            ST_WREN_ARM: begin
                if (busy_i) begin
                    state_d = ST_ENGINE;
                end else if (bit_stb_i) begin
                    state_d = ST_IDLE;
                end else if (sel_n_i) begin
                    set_wel = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_SR_HOLD: begin
                if (busy_i) begin
                    state_d = ST_ENGINE;
                end else if (!sr_ok_i) begin
                    state_d = ST_IDLE;
                end else if (sel_n_i) begin
                    do_commit = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_ENGINE: begin
                if (!busy_i) begin
                    clr_wel = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and data registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_o    <= 1'b0;
            nv_o     <= RST_NV;
            pend_q   <= 8'h00;
            commit_o <= 1'b0;
        end else begin
            commit_o <= do_commit;
            if (take_byte) pend_q <= wrsr_byte_i;
            if (do_commit) nv_o <= (nv_o & ~SR_WR_MASK) | (pend_q & SR_WR_MASK);
            if (set_wel)      wel_o <= 1'b1;
            else if (clr_wel) wel_o <= 1'b0;
        end
    end

endmodule

// File: rtl/wsp_status_guard.sv
module wsp_status_guard #(
    parameter int unsigned ADDR_W   = 11,
    parameter logic        RST_WPEN = 1'b0,
    parameter logic [1:0]  RST_BP   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              bit_stb_i,
    input  logic              wren_stb_i,
    input  logic              wrdi_stb_i,
    input  logic              wrsr_stb_i,
    input  logic [7:0]        wrsr_byte_i,
    input  logic              wp_n_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic [7:0]        status_o,
    output logic              array_wr_ok_o,
    output logic              sr_wr_ok_o,
    output logic              sr_commit_o
);
    import wsp_pkg::*;

    localparam logic [7:0] RST_NV = {RST_WPEN, 3'b000, RST_BP, 2'b00};

    logic       wel;
    logic [7:0] nv;
    logic       in_prot;
    logic       sr_ok;

    wsp_block_map #(.ADDR_W(ADDR_W)) u_map (
        .bp_i      (nv[SR_BP_HI:SR_BP_LO]),
        .addr_i    (wr_addr_i),
        .in_prot_o (in_prot)
    );

    wsp_guard u_guard (
        .wel_i      (wel),
        .wpen_i     (nv[SR_WPEN_BIT]),
        .wp_n_i     (wp_n_i),
        .in_prot_i  (in_prot),
        .array_ok_o (array_wr_ok_o),
        .sr_ok_o    (sr_ok)
    );

    wsp_seq #(.RST_NV(RST_NV)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n_i     (sel_n_i),
        .bit_stb_i   (bit_stb_i),
        .wren_stb_i  (wren_stb_i),
        .wrdi_stb_i  (wrdi_stb_i),
        .wrsr_stb_i  (wrsr_stb_i),
        .wrsr_byte_i (wrsr_byte_i),
        .busy_i      (busy_i),
        .sr_ok_i     (sr_ok),
        .wel_o       (wel),
        .nv_o        (nv),
        .commit_o    (sr_commit_o)
    );

    assign sr_wr_ok_o = sr_ok;
    assign status_o   = pack_status(nv, wel, busy_i);

endmodule

// File: rtl/wsp_status_guard_chk.sv
module wsp_status_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n_i,
    input logic       busy_i,
    input logic [7:0] status_o,
    input logic       array_wr_ok_o,
    input logic       sr_wr_ok_o,
    input logic       sr_commit_o
);
    assert_ro_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

    assert_rdy_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] == busy_i);

    assert_array_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        array_wr_ok_o |-> status_o[1]);

    assert_full_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b11) |-> !array_wr_ok_o);

    assert_sr_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_ok_o |-> status_o[1]);

    assert_pin_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_ok_o && !wp_n_i) |-> !status_o[7]);

    assert_nv_only_on_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_commit_o |-> $stable({status_o[7], status_o[3:2]}));

    assert_commit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_commit_o |=> !sr_commit_o);

    assert_no_wel_rise_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !$rose(status_o[1]));

    assert_wel_clear_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_i) |=> !status_o[1]);

endmodule

bind wsp_status_guard wsp_status_guard_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wp_n_i        (wp_n_i),
    .busy_i        (busy_i),
    .status_o      (status_o),
    .array_wr_ok_o (array_wr_ok_o),
    .sr_wr_ok_o    (sr_wr_ok_o),
    .sr_commit_o   (sr_commit_o)
);

// File: tb/sim_wsp_status_guard.sv
module sim_wsp_status_guard;
    localparam int unsigned ADDR_W = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_n = 1'b1;
    logic              bit_stb = 1'b0;
    logic              wren_stb = 1'b0;
    logic              wrdi_stb = 1'b0;
    logic              wrsr_stb = 1'b0;
    logic [7:0]        wrsr_byte = 8'h00;
    logic              wp_n = 1'b1;
    logic              busy = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        status;
    logic              array_ok, sr_ok, commit;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wsp_status_guard #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .bit_stb_i(bit_stb),
        .wren_stb_i(wren_stb), .wrdi_stb_i(wrdi_stb), .wrsr_stb_i(wrsr_stb),
        .wrsr_byte_i(wrsr_byte), .wp_n_i(wp_n), .busy_i(busy), .wr_addr_i(addr),
        .status_o(status), .array_wr_ok_o(array_ok), .sr_wr_ok_o(sr_ok),
        .sr_commit_o(commit)
    );

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic wren_seq(input bit extra_bit);
        sel_n = 1'b0; wren_stb = 1'b1;
        tick;
        wren_stb = 1'b0;
        if (extra_bit) begin
            bit_stb = 1'b1; tick; bit_stb = 1'b0;
        end
        sel_n = 1'b1;
        tick;
    endtask

    task automatic wrdi_seq;
        wrdi_stb = 1'b1; tick; wrdi_stb = 1'b0;
    endtask

    // mode 0: clean, 1: wp drops before cs rise, 2: wp drops with cs rise
    task automatic wrsr_seq(input logic [7:0] b, input int mode, output bit done);
        sel_n = 1'b0; wrsr_stb = 1'b1; wrsr_byte = b;
        tick;
        wrsr_stb = 1'b0;
        if (mode == 1) begin
            wp_n = 1'b0; tick;
        end
        sel_n = 1'b1;
        if (mode == 2) wp_n = 1'b0;
        tick;
        done = commit;
        tick;
    endtask

    task automatic engine(input int n);
        busy = 1'b1;
        for (int i = 0; i < n; i++) tick;
        busy = 1'b0;
        tick;
    endtask

    task automatic set_nv(input logic [7:0] b);
        bit d;
        wren_seq(1'b0);
        wrsr_seq(b, 0, d);
        engine(3);
    endtask

    task automatic t_reset;
        chk("R1", "reset status", status, 8'h00);
        chk("R1", "reset array permit", array_ok, 1'b0);
        chk("R1", "reset status permit", sr_ok, 1'b0);
        chk("R1", "reset commit", commit, 1'b0);
    endtask

    task automatic t_rdy;
        busy = 1'b1; #1;
        chk("R2", "busy high rdy", status, 8'h01);
        tick;
        busy = 1'b0; #1;
        chk("R2", "busy low rdy", status, 8'h00);
        tick;
    endtask

    task automatic t_wren;
        wren_seq(1'b1);
        chk("R3", "wren then extra bit", status, 8'h00);
        wren_seq(1'b0);
        chk("R3", "wren clean", status, 8'h02);
    endtask

    task automatic t_wrdi;
        wrdi_seq;
        chk("R4", "wrdi clears latch", status[1], 1'b0);
    endtask

    task automatic t_map;
        set_nv(8'h04);
        chk("R5", "bp quarter stored", status, 8'h04);
        wren_seq(1'b0);
        addr = 11'h5FF; #1; chk("R5", "quarter 5FF", array_ok, 1'b1);
        addr = 11'h600; #1; chk("R5", "quarter 600", array_ok, 1'b0);
        addr = 11'h7FF; #1; chk("R5", "quarter 7FF", array_ok, 1'b0);
        set_nv(8'h08);
        wren_seq(1'b0);
        addr = 11'h3FF; #1; chk("R5", "half 3FF", array_ok, 1'b1);
        addr = 11'h400; #1; chk("R5", "half 400", array_ok, 1'b0);
        set_nv(8'h0C);
        wren_seq(1'b0);
        addr = 11'h000; #1; chk("R5", "full 000", array_ok, 1'b0);
        set_nv(8'h00);
        wren_seq(1'b0);
        addr = 11'h7FF; #1; chk("R5", "none 7FF", array_ok, 1'b1);
        wrdi_seq;
        addr = 11'h000; #1; chk("R5", "no latch 000", array_ok, 1'b0);
    endtask

    task automatic t_mask;
        bit d;
        wren_seq(1'b0);
        wrsr_seq(8'hFF, 0, d);
        chk("R7", "commit pulse", d, 1'b1);
        chk("R7", "only bits 7,3,2 written", status, 8'h8E);
        chk("R7", "pulse single", commit, 1'b0);
        engine(2);
        chk("R11", "latch after engine", status, 8'h8C);
    endtask

    task automatic t_guard;
        bit d;
        wren_seq(1'b0);
        wp_n = 1'b0; #1;
        chk("R6", "pin lock", sr_ok, 1'b0);
        wp_n = 1'b1; #1;
        chk("R6", "pin released", sr_ok, 1'b1);
        wp_n = 1'b0;
        wrsr_seq(8'h00, 0, d);
        chk("R8", "rejected no commit", d, 1'b0);
        chk("R8", "rejected status kept", status, 8'h8E);
        wp_n = 1'b1;
        tick;
    endtask

    task automatic t_wp_abort;
        bit d;
        wrsr_seq(8'h00, 1, d);
        chk("R9", "wp drop before cs", d, 1'b0);
        chk("R9", "status after drop", status, 8'h8E);
        wp_n = 1'b1; tick;
        wrsr_seq(8'h00, 2, d);
        chk("R9", "wp drop with cs", d, 1'b0);
        chk("R9", "status after same-cycle drop", status, 8'h8E);
        wp_n = 1'b1; tick;
        wrsr_seq(8'h00, 0, d);
        chk("R9", "clean commit after aborts", d, 1'b1);
        chk("R9", "status cleared", status, 8'h02);
        engine(2);
        wren_seq(1'b0);
        wrsr_seq(8'h0C, 1, d);
        chk("R9", "wp ignored without wpen", d, 1'b1);
        wp_n = 1'b1;
        engine(2);
        chk("R9", "bp written without wpen", status, 8'h0C);
        wrsr_seq(8'h00, 0, d);
        chk("R8", "no latch no commit", d, 1'b0);
        chk("R8", "no latch status kept", status, 8'h0C);
        set_nv(8'h00);
    endtask

    task automatic t_busy;
        bit d;
        wren_seq(1'b0);
        busy = 1'b1; tick;
        wrdi_seq;
        chk("R10", "wrdi ignored busy", status, 8'h03);
        wrsr_seq(8'h0C, 0, d);
        chk("R10", "wrsr ignored busy", d, 1'b0);
        chk("R10", "status kept busy", status, 8'h03);
        busy = 1'b0; tick;
        chk("R11", "latch cleared on busy fall", status, 8'h00);
        busy = 1'b1; tick;
        wren_seq(1'b0);
        chk("R10", "wren ignored busy", status, 8'h01);
        busy = 1'b0; tick;
        chk("R10", "latch still clear", status, 8'h00);
    endtask

    initial begin
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        t_reset;
        t_rdy;
        t_wren;
        t_wrdi;
        t_map;
        t_mask;
        t_guard;
        t_wp_abort;
        t_busy;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

endmodule